// File: doc/BRIEF.md
# PRBS Receive Checker with Bit and Error Tallies

This block sits behind a receiver and checks a link under test for bit errors. It takes one parallel word per valid cycle and can invert all of its bits before checking. It locks onto the selected test pattern without needing a seed from outside. Four pseudo-random sequences and two clock-like patterns can be selected. While the block is hunting for lock, it predicts each bit from bits it has already received. Once it has seen enough clean words, it runs its own sequence history independently of the line. From then on, a corrupted bit is counted once, and the error does not spread into the bits after it.

While locked, the block keeps two tallies: the number of bits checked and the number of bits that mismatched. Software computes the bit error ratio from the two. A dedicated clear pulse zeroes both tallies. It is meant to be issued once the link has settled, so that garbage from before lock is not counted. Both tallies stop at full scale instead of wrapping.

Top module: `prbs_rx_checker`

## Requirements
- R1: `patSel` chooses the expected sequence. Each rule gives bit n in terms of earlier bits.
  - 0 is PRBS-7: b[n] = b[n-7]^b[n-6].
  - 1 is PRBS-15: b[n] = b[n-15]^b[n-14].
  - 2 is PRBS-23: b[n] = b[n-23]^b[n-18].
  - 3 is PRBS-31: b[n] = b[n-31]^b[n-28].
  - 4 is the 2x clock, alternating bits: b[n] = ~b[n-1].
  - 5 is the 10x clock, five ones then five zeros: b[n] = ~b[n-5].
  - Values 6 and 7 act as 0.
  - Within a word, bit DATA_W-1 is the earliest in time.
- R2: When `polInv` is 1, every bit of `rxData` is inverted before it is checked. A bit-inverted pattern then checks clean. With `polInv` at 0, the same inverted PRBS stream never locks.
- R3: Starting from reset or from loss of lock, `locked` rises in the cycle after the fourth consecutive valid word with no mismatch. For a clean stream from reset, that happens after no fewer than 4 and no more than 6 words when DATA_W is 16.
- R4: While locked, a word is bad when more than DATA_W/4 of its bits mismatch. Exactly DATA_W/4 mismatches does not make a word bad. `locked` falls after the fourth consecutive bad valid word, and a word that is not bad restarts that run.
- R5: Each valid word that arrives while `locked` is already 1 adds DATA_W to `bitCount`.
- R6: Each such word adds the number of mismatching bits to `errCount`. A single flipped bit in one word adds exactly 1 and leaves `locked` at 1.
- R7: Words that arrive while unlocked change neither tally. Cycles with `rxValid` at 0 change neither tally nor lock, and they do not advance the expected sequence.
- R8: `bitCount` (BIT_CNT_W bits) and `errCount` (ERR_CNT_W bits) each stop at all-ones and never wrap.
- R9: A `cntClr` pulse zeroes both tallies in the next cycle, even if a counted word arrives in the same cycle. It does not change `locked`.
- R10: After a synchronous `rst`, `locked` is 0 and both tallies are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| patSel | input | 3 | Pattern select (encoding in R1) |
| polInv | input | 1 | Invert received bits before checking |
| cntClr | input | 1 | One-cycle pulse that zeroes both tallies |
| rxValid | input | 1 | `rxData` carries a word this cycle |
| rxData | input | DATA_W | Received word, MSB earliest |
| locked | output | 1 | Checker is locked to the pattern |
| bitCount | output | BIT_CNT_W | Saturating count of bits checked while locked |
| errCount | output | ERR_CNT_W | Saturating count of mismatched bits while locked |

## Verification
The bench builds the checker with DATA_W of 16, BIT_CNT_W of 12 and ERR_CNT_W of 8. The narrow tallies let both saturation points be reached in a few hundred words. Because 4095 is not a multiple of 16, the bit tally visibly clamps instead of landing on full scale. The 16-bit word is shorter than the PRBS-31 history, so the bench also covers the case where seeding from the line spans two words before lock can be earned.

// File: rtl/prbs_rx_pkg.sv
package prbs_rx_pkg;

  // Longest history any pattern needs (PRBS-31).
  localparam int HIST_W = 31;

  // Per-pattern recurrence: next = h[tapA] ^ (useB & h[tapB]) ^ inv,
  // where h[k] is the bit k+1 positions back in time.
  typedef struct packed {
    logic [4:0] tapA;
    logic [4:0] tapB;
    logic       useB;
    logic       inv;
  } tapCfg_t;

  typedef enum logic [2:0] {
    PAT_PRBS7  = 3'd0,
    PAT_PRBS15 = 3'd1,
    PAT_PRBS23 = 3'd2,
    PAT_PRBS31 = 3'd3,
    PAT_CLK2   = 3'd4,
    PAT_CLK10  = 3'd5
  } patSel_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic freeRun;  // predict from own history instead of the line
    logic tally;    // add this word to the tallies
    logic clear;    // zero both tallies
  } ctrlStrobe_t;

  function automatic tapCfg_t tapsFor(input logic [2:0] sel);
    tapCfg_t c;
    case (sel)
      PAT_PRBS15: c = '{tapA: 5'd14, tapB: 5'd13, useB: 1'b1, inv: 1'b0};
      PAT_PRBS23: c = '{tapA: 5'd22, tapB: 5'd17, useB: 1'b1, inv: 1'b0};
      PAT_PRBS31: c = '{tapA: 5'd30, tapB: 5'd27, useB: 1'b1, inv: 1'b0};
      PAT_CLK2:   c = '{tapA: 5'd0,  tapB: 5'd0,  useB: 1'b0, inv: 1'b1};
      PAT_CLK10:  c = '{tapA: 5'd4,  tapB: 5'd0,  useB: 1'b0, inv: 1'b1};
      default:    c = '{tapA: 5'd6,  tapB: 5'd5,  useB: 1'b1, inv: 1'b0};
    endcase
    return c;
  endfunction

endpackage

// File: rtl/prbs_sat_acc.sv
module prbs_sat_acc #(
  parameter int W     = 32,
  parameter int INC_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             add,
  input  logic [INC_W-1:0] inc,
  output logic [W-1:0]     count
);

  localparam int PAD_W = W + 1 - INC_W;

  logic [W:0] sum;

  always_comb sum = {1'b0, count} + {{PAD_W{1'b0}}, inc};

  always_ff @(posedge clk) begin
    if (rst || clr)
      count <= '0;
    else if (add)
      count <= sum[W] ? {W{1'b1}} : sum[W-1:0];
  end

  // R9: a clear empties the tally on the next edge.
  p_clear_zero_r9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(clr) |-> count == '0);

  // R8: without a clear the tally never moves down (no wrap).
  p_no_wrap_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && !$past(clr) |-> count >= $past(count));

  // R7: no add request, no change.
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && !$past(clr) && !$past(add) |-> $stable(count));

endmodule

// File: rtl/prbs_rx_ctrl.sv
module prbs_rx_ctrl
  import prbs_rx_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int ERR_W      = 5,
  parameter int LOCK_WORDS = 4,
  parameter int LOSS_WORDS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             validIn,
  input  logic             cntClr,
  input  logic [ERR_W-1:0] wordErrs,
  output ctrlStrobe_t      strobe,
  output logic             locked
);

  localparam int BAD_LIM = DATA_W / 4;
  localparam int RUN_MAX = (LOCK_WORDS > LOSS_WORDS) ? LOCK_WORDS : LOSS_WORDS;
  localparam int RUN_W   = $clog2(RUN_MAX + 1);

  typedef enum logic {ST_HUNT, ST_TRACK} lockState_e;

  lockState_e       state;
  logic [RUN_W-1:0] goodRun;
  logic [RUN_W-1:0] badRun;
  logic             wordClean;
  logic             wordBad;

  always_comb begin
    wordClean = (wordErrs == '0);
    wordBad   = (32'(wordErrs) > BAD_LIM);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_HUNT;
      goodRun <= '0;
      badRun  <= '0;
    end else if (validIn) begin
      case (state)
        ST_HUNT: begin
          badRun <= '0;
          if (!wordClean)
            goodRun <= '0;
          else if (goodRun == RUN_W'(LOCK_WORDS - 1)) begin
            state   <= ST_TRACK;
            goodRun <= '0;
          end else
            goodRun <= goodRun + 1'b1;
        end
        default: begin
          goodRun <= '0;
          if (!wordBad)
            badRun <= '0;
          else if (badRun == RUN_W'(LOSS_WORDS - 1)) begin
            state  <= ST_HUNT;
            badRun <= '0;
          end else
            badRun <= badRun + 1'b1;
        end
      endcase
    end
  end

  always_comb begin
    locked         = (state == ST_TRACK);
    strobe.freeRun = locked;
    strobe.tally   = validIn && locked;
    strobe.clear   = cntClr;
  end

  // R3: lock is only granted on a valid, mismatch-free word.
  p_lock_on_clean_r3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $rose(locked) |-> $past(validIn) && $past(wordErrs) == '0);

  // R4: lock is only dropped on a valid word above the quarter limit.
  p_drop_on_bad_r4: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $fell(locked) |-> $past(validIn) && 32'($past(wordErrs)) > BAD_LIM);

  // R7: idle cycles leave the lock state alone.
  p_idle_keeps_lock_r7: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && !$past(validIn) |-> $stable(locked));

  // R9: a tally clear never moves the lock state by itself.
  p_clear_keeps_lock_r9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(cntClr) && !$past(validIn) |-> $stable(locked));

endmodule

// File: rtl/prbs_rx_datapath.sv
module prbs_rx_datapath
  import prbs_rx_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int BIT_CNT_W = 48,
  parameter int ERR_CNT_W = 32,
  parameter int ERR_W     = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [2:0]           patSel,
  input  logic                 polInv,
  input  logic                 validIn,
  input  logic [DATA_W-1:0]    rxData,
  input  ctrlStrobe_t          strobe,
  output logic [ERR_W-1:0]     wordErrs,
  output logic [BIT_CNT_W-1:0] bitCount,
  output logic [ERR_CNT_W-1:0] errCount
);

  tapCfg_t             cfg;
  logic [DATA_W-1:0]   rxPol;
  logic [DATA_W-1:0]   predWord;
  logic [DATA_W-1:0]   errVec;
  logic [HIST_W-1:0]   hist;
  logic [HIST_W-1:0]   histNext;
  logic [HIST_W-1:0]   walk;
  logic                nextBit;

  always_comb begin
    cfg   = tapsFor(patSel);
    rxPol = rxData ^ {DATA_W{polInv}};
  end

  // Bit-serial prediction unrolled across the word, earliest bit first.
  // Hunting: history advances with line bits (self-seeding).
  // Locked: history advances with predicted bits only.
  always_comb begin
    walk = hist;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      nextBit     = walk[cfg.tapA] ^ (cfg.useB & walk[cfg.tapB]) ^ cfg.inv;
      predWord[i] = nextBit;
      walk        = {walk[HIST_W-2:0], strobe.freeRun ? nextBit : rxPol[i]};
    end
    histNext = walk;
  end

  always_ff @(posedge clk) begin
    if (rst)
      hist <= '0;
    else if (validIn)
      hist <= histNext;
  end

  always_comb begin
    errVec   = rxPol ^ predWord;
    wordErrs = '0;
    for (int i = 0; i < DATA_W; i++)
      wordErrs = wordErrs + ERR_W'(errVec[i]);
  end

  prbs_sat_acc #(.W(BIT_CNT_W), .INC_W(ERR_W)) bitAcc (
    .clk   (clk),
    .rst   (rst),
    .clr   (strobe.clear),
    .add   (strobe.tally),
    .inc   (ERR_W'(DATA_W)),
    .count (bitCount)
  );

  prbs_sat_acc #(.W(ERR_CNT_W), .INC_W(ERR_W)) errAcc (
    .clk   (clk),
    .rst   (rst),
    .clr   (strobe.clear),
    .add   (strobe.tally),
    .inc   (wordErrs),
    .count (errCount)
  );

  // R7: the sequence history moves only on valid words.
  p_hist_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && !$past(validIn) |-> $stable(hist));

  // R6: one word never adds more errors than it has bits.
  p_err_step_r6: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && !$past(strobe.clear) |-> 64'(errCount) <= 64'($past(errCount)) + DATA_W);

endmodule

// File: rtl/prbs_rx_checker.sv
module prbs_rx_checker
  import prbs_rx_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int BIT_CNT_W  = 48,
  parameter int ERR_CNT_W  = 32,
  parameter int LOCK_WORDS = 4,
  parameter int LOSS_WORDS = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [2:0]           patSel,
  input  logic                 polInv,
  input  logic                 cntClr,
  input  logic                 rxValid,
  input  logic [DATA_W-1:0]    rxData,
  output logic                 locked,
  output logic [BIT_CNT_W-1:0] bitCount,
  output logic [ERR_CNT_W-1:0] errCount
);

  localparam int ERR_W = $clog2(DATA_W + 1);

  ctrlStrobe_t      strobe;
  logic [ERR_W-1:0] wordErrs;

  prbs_rx_ctrl #(
    .DATA_W     (DATA_W),
    .ERR_W      (ERR_W),
    .LOCK_WORDS (LOCK_WORDS),
    .LOSS_WORDS (LOSS_WORDS)
  ) ctrl (
    .clk      (clk),
    .rst      (rst),
    .validIn  (rxValid),
    .cntClr   (cntClr),
    .wordErrs (wordErrs),
    .strobe   (strobe),
    .locked   (locked)
  );

  prbs_rx_datapath #(
    .DATA_W    (DATA_W),
    .BIT_CNT_W (BIT_CNT_W),
    .ERR_CNT_W (ERR_CNT_W),
    .ERR_W     (ERR_W)
  ) dp (
    .clk      (clk),
    .rst      (rst),
    .patSel   (patSel),
    .polInv   (polInv),
    .validIn  (rxValid),
    .rxData   (rxData),
    .strobe   (strobe),
    .wordErrs (wordErrs),
    .bitCount (bitCount),
    .errCount (errCount)
  );

  // R10: reset leaves the checker unlocked with empty tallies.
  p_reset_state_r10: assert property (@(posedge clk)
    $past(rst) |-> !locked && bitCount == '0 && errCount == '0);

endmodule

// File: tb/prbs_rx_checker_test.sv
`timescale 1ns/1ps
module prbs_rx_checker_test;

  localparam int DW = 16;
  localparam int BW = 12;
  localparam int EW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    patSel = 3'd0;
  logic          polInv = 1'b0;
  logic          cntClr = 1'b0;
  logic          rxValid = 1'b0;
  logic [DW-1:0] rxData = '0;
  logic          locked;
  logic [BW-1:0] bitCount;
  logic [EW-1:0] errCount;

  int nChecks = 0;
  int nFail   = 0;

  // Reference stream state.
  logic [2:0]  genPat = 3'd0;
  logic [30:0] genHist = '1;
  int          genIdx = 0;
  logic        wireInv = 1'b0;

  always #2.5 clk = ~clk;

  prbs_rx_checker #(.DATA_W(DW), .BIT_CNT_W(BW), .ERR_CNT_W(EW)) uut (
    .clk(clk), .rst(rst), .patSel(patSel), .polInv(polInv), .cntClr(cntClr),
    .rxValid(rxValid), .rxData(rxData), .locked(locked),
    .bitCount(bitCount), .errCount(errCount)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic genBit(output logic b);
    case (genPat)
      3'd1: b = genHist[14] ^ genHist[13];
      3'd2: b = genHist[22] ^ genHist[17];
      3'd3: b = genHist[30] ^ genHist[27];
      3'd4: b = (genIdx % 2) == 1;
      3'd5: b = (genIdx % 10) < 5;
      default: b = genHist[6] ^ genHist[5];
    endcase
    genHist = {genHist[29:0], b};
    genIdx++;
  endtask

  task automatic genWord(output logic [DW-1:0] w);
    for (int i = DW - 1; i >= 0; i--) begin
      logic b;
      genBit(b);
      w[i] = b;
    end
  endtask

  task automatic startPattern(input logic [2:0] p);
    genPat  = p;
    genHist = '1;
    genIdx  = 0;
    patSel  = p;
  endtask

  task automatic sendWord(input logic [DW-1:0] mask);
    logic [DW-1:0] w;
    genWord(w);
    rxData  = w ^ mask ^ {DW{wireInv}};
    rxValid = 1'b1;
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  task automatic doReset();
    rst = 1'b1; cntClr = 1'b0; rxValid = 1'b0; polInv = 1'b0; wireInv = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic clearPulse();
    cntClr = 1'b1;
    @(negedge clk);
    cntClr = 1'b0;
  endtask

  task automatic acquire(output int n);
    n = 0;
    while (!locked && n < 12) begin
      sendWord('0);
      n++;
    end
  endtask

  task automatic t_reset();
    doReset();
    check(!locked, "R10 locked after reset", locked, 0);
    check(bitCount == 0 && errCount == 0, "R10 tallies after reset", bitCount + errCount, 0);
  endtask

  task automatic t_patterns();
    for (int p = 0; p < 6; p++) begin
      int n;
      doReset();
      startPattern(3'(p));
      repeat (3) sendWord('0);
      check(!locked, "R3 no lock before four words", locked, 0);
      check(bitCount == 0, "R7 no bit tally while hunting", bitCount, 0);
      acquire(n);
      n += 3;
      check(locked && n >= 4 && n <= 6, "R3 lock word count", n, 6);
      clearPulse();
      repeat (8) sendWord('0);
      check(bitCount == 128, "R5 bits for eight words", bitCount, 128);
      check(errCount == 0, "R1 clean pattern has no errors", errCount, 0);
    end
  endtask

  task automatic t_polarity();
    int n;
    doReset();
    startPattern(3'd1);
    wireInv = 1'b1;
    repeat (12) sendWord('0);
    check(!locked, "R2 inverted stream without invert stays unlocked", locked, 0);
    polInv = 1'b1;
    acquire(n);
    check(locked && n <= 6, "R2 lock after invert enabled", n, 6);
    clearPulse();
    repeat (6) sendWord('0);
    check(errCount == 0 && bitCount == 96, "R2 inverted stream checks clean", errCount, 0);
  endtask

  task automatic t_single_flip();
    int n;
    doReset();
    startPattern(3'd3);
    acquire(n);
    clearPulse();
    repeat (2) sendWord('0);
    sendWord(16'h0100);
    repeat (3) sendWord('0);
    check(errCount == 1, "R6 single flip counts one", errCount, 1);
    check(locked, "R6 single flip keeps lock", locked, 1);
    check(bitCount == 96, "R5 bits include flipped word", bitCount, 96);
  endtask

  task automatic t_loss();
    int n;
    doReset();
    startPattern(3'd2);
    acquire(n);
    clearPulse();
    repeat (3) sendWord('1);
    check(locked && errCount == 48, "R4 three bad words keep lock", errCount, 48);
    sendWord('0);
    repeat (3) sendWord('1);
    check(locked, "R4 clean word restarts bad run", locked, 1);
    sendWord('1);
    check(!locked, "R4 fourth bad word drops lock", locked, 0);
    check(errCount == 112 && bitCount == 128, "R6 bad words counted", errCount, 112);
    repeat (3) sendWord('0);
    check(!locked && bitCount == 128, "R7 hunting words not tallied", bitCount, 128);
    sendWord('0);
    check(locked, "R3 relock after four clean words", locked, 1);
  endtask

  task automatic t_idle();
    int n;
    logic [BW-1:0] b0;
    logic [EW-1:0] e0;
    doReset();
    startPattern(3'd5);
    acquire(n);
    repeat (2) sendWord('0);
    b0 = bitCount; e0 = errCount;
    rxData = 16'hA5C3;
    repeat (5) @(negedge clk);
    check(bitCount == b0 && errCount == e0 && locked, "R7 idle cycles change nothing", bitCount, b0);
    repeat (4) sendWord('0);
    check(errCount == e0 && bitCount == b0 + 64, "R7 sequence resumes after idle", errCount, e0);
  endtask

  task automatic t_clear();
    int n;
    doReset();
    startPattern(3'd4);
    acquire(n);
    repeat (3) sendWord(16'h0001);
    cntClr = 1'b1;
    sendWord(16'h0003);
    cntClr = 1'b0;
    check(bitCount == 0 && errCount == 0, "R9 clear beats same-cycle word", bitCount + errCount, 0);
    check(locked, "R9 clear keeps lock", locked, 1);
    repeat (2) sendWord(16'h0001);
    clearPulse();
    check(bitCount == 0 && errCount == 0 && locked, "R9 standalone clear", bitCount + errCount, 0);
  endtask

  task automatic t_saturate();
    int n;
    doReset();
    startPattern(3'd0);
    acquire(n);
    clearPulse();
    repeat (255) sendWord('0);
    check(bitCount == 4080, "R5 bits before saturation", bitCount, 4080);
    sendWord('0);
    check(bitCount == 4095, "R8 bit tally clamps", bitCount, 4095);
    sendWord('0);
    check(bitCount == 4095, "R8 bit tally holds at full scale", bitCount, 4095);
    clearPulse();
    repeat (63) sendWord(16'h1111);
    check(errCount == 252 && locked, "R4 quarter errors keep lock", errCount, 252);
    sendWord(16'h1111);
    check(errCount == 255, "R8 error tally clamps", errCount, 255);
    sendWord(16'h1111);
    check(errCount == 255 && locked, "R8 error tally holds", errCount, 255);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_patterns();
    t_polarity();
    t_single_flip();
    t_loss();
    t_idle();
    t_clear();
    t_saturate();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule